// File: doc/BRIEF.md
# Serial 1001 Pattern Recognizer on JK State Cells

This block watches a serial bit stream, taking one bit on each rising clock edge, and flags every place where the stream contains the pattern 1001. The match flag is a Mealy output. It rises combinationally in the same cycle as the last bit of the pattern, so no extra cycle of latency is added. Matches may overlap: the closing 1 of one match also counts as the opening 1 of the next.

Progress through the pattern is held in two JK storage cells that sit in a sub-module of their own. Their J and K inputs come from fixed, minimized boolean equations over the present state and the input bit. There is no behavioural transition table. Both state bits are brought out to ports so that the progress can be observed.

Top module: `pat1001_jk_recognizer`

## Requirements
- R1: While `rst` is high at a rising edge, both state bits become 0, whatever the JK inputs. `hit` is 0 in every cycle where `rst` is high.
- R2: The state code is {`st_hi`,`st_lo`}. The codes are 00 for no progress, 01 after "1", 10 after "10" and 11 after "100". From 00, `din`=0 keeps 00 and `din`=1 moves to 01.
- R3: From 01, `din`=0 moves to 10 and `din`=1 keeps 01.
- R4: From 10, `din`=0 moves to 11 and `din`=1 moves to 01.
- R5: From 11, `din`=0 moves to 00 and `din`=1 moves to 01.
- R6: `hit` is 1 exactly when the state is 11, `din` is 1 and `rst` is low. It follows `din` in the same cycle, before the clock edge.
- R7: After a match the state is 01, so overlapping occurrences are all detected. The stream 1001001001 yields `hit` on bits 4, 7 and 10.
- R8: Each state cell holds for JK=00, clears for 01, sets for 10 and toggles for 11. The cells are driven by J_hi = !din & st_lo, K_hi = din | st_lo, J_lo = din | st_hi and K_lo = !din.
- R9: For the input 11100110100100110 the `hit` stream is 00000100000100100. Over a pseudo-random stream of 2000 bits, `hit` and the state always agree with a behavioural reference machine.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit, one per clock |
| hit | output | 1 | Combinational match flag for the final bit of 1001 |
| st_hi | output | 1 | High state bit |
| st_lo | output | 1 | Low state bit |

## Verification
The bench visits all eight pairs of state and input bit, checking `hit` before the edge and the state after it. An equation with a swapped or inverted term would send one of these pairs to the wrong code, for example leaving 10 instead of advancing to 11. Back-to-back overlapping matches would expose a machine that returns to 00 after a hit, because it would drop the second and third detections. Asserting reset while the state is 11 and `din` is 1 would catch a flag that ignores reset. A long random stream compared against a behavioural machine covers recoveries from partial matches, such as 1101 or 10001, that the directed patterns miss.

// File: rtl/pat1001_jk_recognizer.sv
module jk_cell (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else begin
      case ({j, k})
        2'b00:   q <= q;
        2'b01:   q <= 1'b0;
        2'b10:   q <= 1'b1;
        default: q <= ~q;
      endcase
    end
  end
endmodule

module pat1001_jk_recognizer (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit,
  output logic st_hi,
  output logic st_lo
);
  logic j_hi, k_hi, j_lo, k_lo;

  assign j_hi = ~din & st_lo;
  assign k_hi = din | st_lo;
  assign j_lo = din | st_hi;
  assign k_lo = ~din;

  jk_cell u_hi (.clk(clk), .rst(rst), .j(j_hi), .k(k_hi), .q(st_hi));
  jk_cell u_lo (.clk(clk), .rst(rst), .j(j_lo), .k(k_lo), .q(st_lo));

  assign hit = st_hi & st_lo & din & ~rst;
endmodule

// File: rtl/pat1001_checker.sv
module pat1001_checker (
  input logic clk,
  input logic rst,
  input logic din,
  input logic hit,
  input logic st_hi,
  input logic st_lo,
  input logic j_hi,
  input logic k_hi,
  input logic j_lo,
  input logic k_lo
);
  logic armed = 1'b0;
  logic [1:0] st;
  assign st = {st_hi, st_lo};

  always_ff @(posedge clk) armed <= 1'b1;

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> st == 2'b00);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!armed)
    rst |-> !hit);
  p_idle_step_r2: assert property (@(posedge clk) disable iff (rst)
    (st == 2'b00) |=> st == {1'b0, $past(din)});
  p_one_step_r3: assert property (@(posedge clk) disable iff (rst)
    (st == 2'b01) |=> st == ($past(din) ? 2'b01 : 2'b10));
  p_two_step_r4: assert property (@(posedge clk) disable iff (rst)
    (st == 2'b10) |=> st == ($past(din) ? 2'b01 : 2'b11));
  p_three_step_r5: assert property (@(posedge clk) disable iff (rst)
    (st == 2'b11) |=> st == ($past(din) ? 2'b01 : 2'b00));
  p_hit_cause_r6: assert property (@(posedge clk) disable iff (rst)
    hit |-> (st == 2'b11) && din);
  p_hit_restart_r7: assert property (@(posedge clk) disable iff (rst)
    hit |=> st == 2'b01);
  p_hi_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!j_hi && !k_hi) |=> $stable(st_hi));
  p_hi_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    (j_hi && k_hi) |=> st_hi != $past(st_hi));
  p_lo_set_r8: assert property (@(posedge clk) disable iff (rst)
    (j_lo && !k_lo) |=> st_lo);
  p_lo_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (!j_lo && k_lo) |=> !st_lo);
endmodule

bind pat1001_jk_recognizer pat1001_checker chk (
  .clk(clk), .rst(rst), .din(din), .hit(hit), .st_hi(st_hi), .st_lo(st_lo),
  .j_hi(j_hi), .k_hi(k_hi), .j_lo(j_lo), .k_lo(k_lo)
);

// File: tb/pat1001_jk_recognizer_test.sv
module pat1001_jk_recognizer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit, st_hi, st_lo;
  int checks = 0;
  int errors = 0;
  logic [1:0] ref_st = 2'b00;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pat1001_jk_recognizer uut (.clk(clk), .rst(rst), .din(din), .hit(hit),
                             .st_hi(st_hi), .st_lo(st_lo));

  function automatic logic [1:0] ref_next(logic [1:0] s, logic b);
    if (b) return 2'b01;
    case (s)
      2'b00:   return 2'b00;
      2'b01:   return 2'b10;
      2'b10:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(logic ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one bit, check hit before the edge and state after it
  task automatic step(logic b, string req);
    logic eh;
    din = b;
    #1;
    eh = (ref_st == 2'b11) && b && !rst;
    check(hit === eh, {req, " hit"}, int'(hit), int'(eh));
    @(posedge clk);
    #1;
    ref_st = rst ? 2'b00 : ref_next(ref_st, b);
    check({st_hi, st_lo} === ref_st, {req, " state"}, int'({st_hi, st_lo}), int'(ref_st));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b1, "R1");
    step(1'b0, "R1");
    rst = 1'b0;
  endtask

  task automatic reach(logic [1:0] s);
    do_reset();
    case (s)
      2'b01: step(1'b1, "R2");
      2'b10: begin step(1'b1, "R2"); step(1'b0, "R3"); end
      2'b11: begin step(1'b1, "R2"); step(1'b0, "R3"); step(1'b0, "R4"); end
      default: ;
    endcase
  endtask

  initial begin
    logic [16:0] dir_in, dir_out;
    logic [9:0] ov_in, ov_out;
    logic [15:0] lfsr;
    @(negedge clk);
    do_reset();
    check({st_hi, st_lo} === 2'b00, "R1 idle", int'({st_hi, st_lo}), 0);

    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 2; b++) begin
        reach(2'(s));
        case (s)
          0: step(1'(b), "R2");
          1: step(1'(b), "R3");
          2: step(1'(b), "R4");
          default: step(1'(b), "R5 R6");
        endcase
      end
    end

    // reset overrides a pending match
    reach(2'b11);
    rst = 1'b1;
    din = 1'b1;
    #1;
    check(hit === 1'b0, "R1 hit under reset", int'(hit), 0);
    step(1'b1, "R1");
    check({st_hi, st_lo} === 2'b00, "R1 reset from 11", int'({st_hi, st_lo}), 0);
    rst = 1'b0;

    // overlap
    do_reset();
    ov_in = 10'b1001001001;
    ov_out = 10'b0001001001;
    for (int i = 9; i >= 0; i--) begin
      din = ov_in[i];
      #1;
      check(hit === ov_out[i], "R7 overlap hit", int'(hit), int'(ov_out[i]));
      step(ov_in[i], "R7");
    end

    // directed stream
    do_reset();
    dir_in = 17'b11100110100100110;
    dir_out = 17'b00000100000100100;
    for (int i = 16; i >= 0; i--) begin
      din = dir_in[i];
      #1;
      check(hit === dir_out[i], "R9 directed hit", int'(hit), int'(dir_out[i]));
      step(dir_in[i], "R9");
    end

    // random stream against reference (covers R8 cell behaviour)
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], "R8 R9 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule